// File: doc/BRIEF.md
# Command Access-Legality Checker for a Remote Memory Access Target

This block sits behind the header decoder of a remote memory access target on a SpaceWire link. For every decoded command it decides whether the requested bus access may go ahead, what status code the reply must carry, and whether the reply must leave out its data. It also diverts every packet to the DMA path when the hardware target is switched off. Packet parsing, CRC computation, the bus master and the reply transmitter are all outside the block.

The decoder presents the command fields and pulses `hdr_valid` for one cycle. The data-CRC result must already be valid in that cycle. The verdict is captured on that clock edge and appears on the outputs one cycle later. It stays unchanged until the next strobe. No data flows through the block, so it has no valid/ready stream and never exerts back-pressure. The decoder may strobe in any cycle, including back to back.

Different commands follow different rules:
- Verified writes and read-modify-write always make a single bus access.
- Non-verified writes and reads may make bursts.

Errors are ranked. Some block the access, and others only mark the reply.

Top module: `rmap_acc_chk`

## Requirements
- R1: For a write (`cmd_type` 2'b01) with `verify`=1, the length must be 0, 1, 2 or 4. Length 2 needs `addr[0]`=0 and length 4 needs `addr[1:0]`=0. Length 3, lengths above 4 and misaligned accesses give status 10 with `accept`=0.
- R2: The `incr` flag has no effect on verified writes or on read-modify-write (`cmd_type` 2'b11), because each makes exactly one bus access.
- R3: A write with `verify`=0 and `incr`=1 is legal for any length and address. With `incr`=0 it needs `len[1:0]`=0 and `addr[1:0]`=0, otherwise it gives status 10.
- R4: A read (`cmd_type` 2'b10) with `incr`=1 is legal for any length and address. With `incr`=0 it follows the R3 rule for `incr`=0.
- R5: Read-modify-write is governed by its length:
  - Length 6 gives status 10.
  - Lengths 2, 4 and 8 access 1, 2 and 4 bytes, and follow the R1 alignment for that size.
  - Lengths 0, 1, 3, 5 and 7 have no alignment rule.
  - Lengths above 8 are still accepted but report status 6.
- R6: A data-CRC failure (`data_crc_ok`=0) is handled by command kind:
  - On a verified write or a read-modify-write it gives status 8 and blocks the access.
  - On a non-verified write the access is still accepted, with status 8.
  - A read ignores `data_crc_ok`.
- R7: A read or read-modify-write with `reply`=0 is an unsupported option. It gives status 10 and is not executed.
- R8: `reply_data_off` is 1 exactly when the registered status is nonzero. An authorization failure is reported even when the length is 0.
- R9: With `tgt_en`=0 every command gives `to_dma`=1, `accept`=0 and status 0. `accept` and `to_dma` are never both 1.
- R10: Errors are ranked as follows, highest first:
  - header CRC failure gives status 1;
  - `cmd_type` 2'b00 gives status 2;
  - `key_hdr` differing from `key_cfg` gives status 3;
  - a rule violation gives status 10;
  - a blocking data-CRC failure gives status 8.

  Each of these sets `accept`=0.
- R11: The outputs reset to all zeros. They are loaded only at a clock edge where `hdr_valid`=1, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | One-cycle strobe: header fields valid |
| cmd_type | input | 2 | 00 unused, 01 write, 10 read, 11 read-modify-write |
| verify | input | 1 | Verify-before-write flag |
| incr | input | 1 | Address increment flag |
| reply | input | 1 | Reply requested flag |
| addr | input | 32 | Start address of the access |
| len | input | 24 | Data length field in bytes |
| key_hdr | input | 8 | Key carried in the command header |
| key_cfg | input | 8 | Destination key from the configuration register |
| tgt_en | input | 1 | Hardware target enable |
| hdr_crc_ok | input | 1 | Header CRC check passed |
| data_crc_ok | input | 1 | Data CRC check passed |
| accept | output | 1 | Perform the bus access |
| to_dma | output | 1 | Divert the packet to the DMA path |
| status | output | 8 | Reply status code |
| reply_data_off | output | 1 | Leave data out of the reply |

## Verification
The assertions assume that every header field, `key_cfg` and `data_crc_ok` are settled and meaningful in the cycle where `hdr_valid` is high. Each verdict property is keyed on that single strobe cycle and checked one cycle later. The bench changes inputs only on falling clock edges and raises the strobe for exactly one cycle per command. It also changes fields while the strobe is low, to confirm that nothing is captured then.

// File: rtl/rmap_chk_pkg.sv
package rmap_chk_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_WR   = 2'b01,
    CMD_RD   = 2'b10,
    CMD_RMW  = 2'b11
  } cmd_e;

  localparam int ST_W = 8;

  localparam logic [ST_W-1:0] ST_OK       = 8'd0;
  localparam logic [ST_W-1:0] ST_HDR_CRC  = 8'd1;
  localparam logic [ST_W-1:0] ST_BAD_TYPE = 8'd2;
  localparam logic [ST_W-1:0] ST_AUTH     = 8'd3;
  localparam logic [ST_W-1:0] ST_CARGO    = 8'd6;
  localparam logic [ST_W-1:0] ST_DATA_CRC = 8'd8;
  localparam logic [ST_W-1:0] ST_UNSUP    = 8'd10;

  typedef struct packed {
    logic            accept;
    logic            to_dma;
    logic [ST_W-1:0] status;
  } verdict_t;

endpackage

// File: rtl/rmap_rule_eval.sv
module rmap_rule_eval
  import rmap_chk_pkg::*;
#(
  parameter int LEN_W   = 24,
  parameter int VW_MAX  = 4,
  parameter int RMW_MAX = 8
) (
  input  cmd_e             kind,
  input  logic             verify,
  input  logic             incr,
  input  logic             reply,
  input  logic [1:0]       addr_lo,
  input  logic [LEN_W-1:0] len,
  output logic             rule_bad,
  output logic             pre_check,
  output logic             cargo_big
);

  localparam logic [LEN_W-1:0] VW_LIM   = LEN_W'(VW_MAX);
  localparam logic [LEN_W-1:0] RMW_LIM  = LEN_W'(RMW_MAX);
  localparam logic [LEN_W-1:0] RMW_HOLE = LEN_W'(6);

  // single bus access of sz bytes: legal sizes and their alignment
  function automatic logic fits(input logic [LEN_W-1:0] sz, input logic [1:0] a);
    logic ok;
    if (sz == LEN_W'(0) || sz == LEN_W'(1)) ok = 1'b1;
    else if (sz == LEN_W'(2))               ok = (a[0] == 1'b0);
    else if (sz == LEN_W'(4))               ok = (a == 2'b00);
    else                                    ok = 1'b0;
    return ok;
  endfunction

  logic word_ok;
  assign word_ok = (len[1:0] == 2'b00) && (addr_lo == 2'b00);

  always_comb begin
    rule_bad  = 1'b0;
    pre_check = 1'b0;
    cargo_big = 1'b0;
    unique case (kind)
      CMD_WR: begin
        if (verify) begin
          pre_check = 1'b1;
          rule_bad  = (len > VW_LIM) || !fits(len, addr_lo);
        end else if (!incr) begin
          rule_bad = !word_ok;
        end
      end
      CMD_RD: begin
        rule_bad = !reply || (!incr && !word_ok);
      end
      CMD_RMW: begin
        pre_check = 1'b1;
        if (!reply)                rule_bad  = 1'b1;
        else if (len == RMW_HOLE)  rule_bad  = 1'b1;
        else if (len > RMW_LIM)    cargo_big = 1'b1;
        else if (len[0] == 1'b0)   rule_bad  = !fits(len >> 1, addr_lo);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rmap_status_prio.sv
module rmap_status_prio
  import rmap_chk_pkg::*;
(
  input  logic     tgt_en,
  input  logic     hdr_crc_ok,
  input  logic     type_bad,
  input  logic     key_bad,
  input  logic     rule_bad,
  input  logic     dcrc_bad,
  input  logic     pre_check,
  input  logic     cargo_big,
  output verdict_t verdict
);

  always_comb begin
    verdict = '{accept: 1'b0, to_dma: 1'b0, status: ST_OK};
    if (!tgt_en) begin
      verdict.to_dma = 1'b1;
    end else if (!hdr_crc_ok) begin
      verdict.status = ST_HDR_CRC;
    end else if (type_bad) begin
      verdict.status = ST_BAD_TYPE;
    end else if (key_bad) begin
      verdict.status = ST_AUTH;
    end else if (rule_bad) begin
      verdict.status = ST_UNSUP;
    end else if (dcrc_bad && pre_check) begin
      verdict.status = ST_DATA_CRC;
    end else begin
      verdict.accept = 1'b1;
      if (dcrc_bad)       verdict.status = ST_DATA_CRC;
      else if (cargo_big) verdict.status = ST_CARGO;
    end
  end

endmodule

// File: rtl/rmap_result_reg.sv
module rmap_result_reg
  import rmap_chk_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  verdict_t        verdict,
  output logic            accept,
  output logic            to_dma,
  output logic [ST_W-1:0] status,
  output logic            data_off
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept   <= 1'b0;
      to_dma   <= 1'b0;
      status   <= ST_OK;
      data_off <= 1'b0;
    end else if (load) begin
      accept   <= verdict.accept;
      to_dma   <= verdict.to_dma;
      status   <= verdict.status;
      data_off <= (verdict.status != ST_OK);
    end
  end

endmodule

// File: rtl/rmap_acc_chk.sv
module rmap_acc_chk
  import rmap_chk_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 24,
  parameter int KEY_W   = 8,
  parameter int VW_MAX  = 4,
  parameter int RMW_MAX = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [1:0]        cmd_type,
  input  logic              verify,
  input  logic              incr,
  input  logic              reply,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [KEY_W-1:0]  key_hdr,
  input  logic [KEY_W-1:0]  key_cfg,
  input  logic              tgt_en,
  input  logic              hdr_crc_ok,
  input  logic              data_crc_ok,
  output logic              accept,
  output logic              to_dma,
  output logic [ST_W-1:0]   status,
  output logic              reply_data_off
);

  cmd_e     kind;
  logic     rule_bad, pre_check, cargo_big;
  logic     key_bad, type_bad, dcrc_bad;
  verdict_t verdict;
  logic     unused_addr_hi;

  assign kind           = cmd_e'(cmd_type);
  assign unused_addr_hi = ^addr[ADDR_W-1:2];
  assign key_bad        = (key_hdr != key_cfg);
  assign type_bad       = (kind == CMD_NONE);
  assign dcrc_bad       = !data_crc_ok && ((kind == CMD_WR) || (kind == CMD_RMW));

  rmap_rule_eval #(
    .LEN_W  (LEN_W),
    .VW_MAX (VW_MAX),
    .RMW_MAX(RMW_MAX)
  ) u_rules (
    .kind     (kind),
    .verify   (verify),
    .incr     (incr),
    .reply    (reply),
    .addr_lo  (addr[1:0]),
    .len      (len),
    .rule_bad (rule_bad),
    .pre_check(pre_check),
    .cargo_big(cargo_big)
  );

  rmap_status_prio u_prio (
    .tgt_en    (tgt_en),
    .hdr_crc_ok(hdr_crc_ok),
    .type_bad  (type_bad),
    .key_bad   (key_bad),
    .rule_bad  (rule_bad),
    .dcrc_bad  (dcrc_bad),
    .pre_check (pre_check),
    .cargo_big (cargo_big),
    .verdict   (verdict)
  );

  rmap_result_reg u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (hdr_valid),
    .verdict (verdict),
    .accept  (accept),
    .to_dma  (to_dma),
    .status  (status),
    .data_off(reply_data_off)
  );

endmodule

// File: rtl/rmap_acc_chk_sva.sv
module rmap_acc_chk_sva #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 24,
  parameter int KEY_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic [1:0]        cmd_type,
  input logic              verify,
  input logic [ADDR_W-1:0] addr,
  input logic [LEN_W-1:0]  len,
  input logic [KEY_W-1:0]  key_hdr,
  input logic [KEY_W-1:0]  key_cfg,
  input logic              tgt_en,
  input logic              hdr_crc_ok,
  input logic              accept,
  input logic              to_dma,
  input logic [7:0]        status,
  input logic              reply_data_off
);

  logic clean_hdr;
  assign clean_hdr = hdr_valid && tgt_en && hdr_crc_ok && (key_hdr == key_cfg);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> $stable(accept) && $stable(to_dma) && $stable(status) && $stable(reply_data_off));

  p_data_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> (reply_data_off == (status != 8'd0)));

  p_divert_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !tgt_en |=> to_dma && !accept && (status == 8'd0));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && to_dma));

  p_auth_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && tgt_en && hdr_crc_ok && (cmd_type != 2'b00) && (key_hdr != key_cfg)
    |=> !accept && (status == 8'd3));

  p_vw_three_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clean_hdr && (cmd_type == 2'b01) && verify && (len == LEN_W'(3))
    |=> !accept && (status == 8'd10));

  p_rmw_six_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clean_hdr && (cmd_type == 2'b11) && (len == LEN_W'(6))
    |=> !accept && (status == 8'd10));

  p_vw_word_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clean_hdr && (cmd_type == 2'b01) && verify && (len == LEN_W'(4)) && (addr[1:0] != 2'b00)
    |=> !accept && (status == 8'd10));

endmodule

bind rmap_acc_chk rmap_acc_chk_sva #(
  .ADDR_W(ADDR_W),
  .LEN_W (LEN_W),
  .KEY_W (KEY_W)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .hdr_valid     (hdr_valid),
  .cmd_type      (cmd_type),
  .verify        (verify),
  .addr          (addr),
  .len           (len),
  .key_hdr       (key_hdr),
  .key_cfg       (key_cfg),
  .tgt_en        (tgt_en),
  .hdr_crc_ok    (hdr_crc_ok),
  .accept        (accept),
  .to_dma        (to_dma),
  .status        (status),
  .reply_data_off(reply_data_off)
);

// File: tb/sim_rmap_acc_chk.sv
module sim_rmap_acc_chk;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] KEY = 8'hA5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [1:0]  cmd_type = 2'b00;
  logic        verify = 1'b0, incr = 1'b0, reply = 1'b1;
  logic [31:0] addr = '0;
  logic [23:0] len = '0;
  logic [7:0]  key_hdr = KEY;
  logic [7:0]  key_cfg = KEY;
  logic        tgt_en = 1'b1, hdr_crc_ok = 1'b1, data_crc_ok = 1'b1;
  logic        accept, to_dma, reply_data_off;
  logic [7:0]  status;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rmap_acc_chk u0 (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .cmd_type(cmd_type),
    .verify(verify), .incr(incr), .reply(reply), .addr(addr), .len(len),
    .key_hdr(key_hdr), .key_cfg(key_cfg), .tgt_en(tgt_en),
    .hdr_crc_ok(hdr_crc_ok), .data_crc_ok(data_crc_ok),
    .accept(accept), .to_dma(to_dma), .status(status),
    .reply_data_off(reply_data_off)
  );

  task automatic chk(input string tag, input logic acc, input logic dma,
                     input logic [7:0] st, input logic off);
    n_run++;
    if ({accept, to_dma, status, reply_data_off} !== {acc, dma, st, off}) begin
      n_fail++;
      $display("FAIL %s: got acc=%0b dma=%0b st=%0d off=%0b, expected acc=%0b dma=%0b st=%0d off=%0b",
               tag, accept, to_dma, status, reply_data_off, acc, dma, st, off);
    end
  endtask

  // drive one command with a one-cycle strobe; returns at the negedge after capture
  task automatic issue(input logic [1:0] t, input logic v, input logic i,
                       input logic r, input logic [31:0] a, input logic [23:0] l,
                       input logic kok, input logic hok, input logic dok, input logic en);
    @(negedge clk);
    cmd_type = t; verify = v; incr = i; reply = r; addr = a; len = l;
    key_hdr = kok ? KEY : ~KEY; hdr_crc_ok = hok; data_crc_ok = dok; tgt_en = en;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 reset", 0, 0, 8'd0, 0);
  endtask

  task automatic t_vwrite();
    issue(2'b01, 1, 0, 1, 32'h3, 24'd1, 1, 1, 1, 1); chk("R1 vw len1 odd addr", 1, 0, 8'd0, 0);
    issue(2'b01, 1, 0, 1, 32'h1, 24'd2, 1, 1, 1, 1); chk("R1 vw len2 misaligned", 0, 0, 8'd10, 1);
    issue(2'b01, 1, 0, 1, 32'h2, 24'd2, 1, 1, 1, 1); chk("R1 vw len2 aligned", 1, 0, 8'd0, 0);
    issue(2'b01, 1, 0, 1, 32'h0, 24'd3, 1, 1, 1, 1); chk("R1 vw len3", 0, 0, 8'd10, 1);
    issue(2'b01, 1, 0, 1, 32'h4, 24'd4, 1, 1, 1, 1); chk("R1 vw len4 aligned", 1, 0, 8'd0, 0);
    issue(2'b01, 1, 0, 1, 32'h2, 24'd4, 1, 1, 1, 1); chk("R1 vw len4 misaligned", 0, 0, 8'd10, 1);
    issue(2'b01, 1, 1, 1, 32'h0, 24'd8, 1, 1, 1, 1); chk("R1 vw len8", 0, 0, 8'd10, 1);
  endtask

  task automatic t_incr_ignored();
    issue(2'b01, 1, 1, 1, 32'h10, 24'd4, 1, 1, 1, 1); chk("R2 vw incr=1", 1, 0, 8'd0, 0);
    issue(2'b01, 1, 0, 1, 32'h10, 24'd4, 1, 1, 1, 1); chk("R2 vw incr=0", 1, 0, 8'd0, 0);
    issue(2'b11, 0, 0, 1, 32'h20, 24'd8, 1, 1, 1, 1); chk("R2 rmw incr=0", 1, 0, 8'd0, 0);
    issue(2'b11, 0, 1, 1, 32'h21, 24'd2, 1, 1, 1, 1); chk("R2 rmw incr=1", 1, 0, 8'd0, 0);
  endtask

  task automatic t_nvwrite();
    issue(2'b01, 0, 1, 1, 32'h3, 24'd13, 1, 1, 1, 1); chk("R3 nvw incr free", 1, 0, 8'd0, 0);
    issue(2'b01, 0, 0, 1, 32'h8, 24'd12, 1, 1, 1, 1); chk("R3 nvw fixed ok", 1, 0, 8'd0, 0);
    issue(2'b01, 0, 0, 1, 32'h0, 24'd10, 1, 1, 1, 1); chk("R3 nvw fixed bad len", 0, 0, 8'd10, 1);
    issue(2'b01, 0, 0, 1, 32'h2, 24'd8, 1, 1, 1, 1);  chk("R3 nvw fixed bad addr", 0, 0, 8'd10, 1);
  endtask

  task automatic t_read();
    issue(2'b10, 0, 1, 1, 32'h1, 24'd7, 1, 1, 1, 1);  chk("R4 rd incr free", 1, 0, 8'd0, 0);
    issue(2'b10, 0, 0, 1, 32'h0, 24'd6, 1, 1, 1, 1);  chk("R4 rd fixed bad len", 0, 0, 8'd10, 1);
    issue(2'b10, 0, 0, 1, 32'h4, 24'd16, 1, 1, 1, 1); chk("R4 rd fixed ok", 1, 0, 8'd0, 0);
  endtask

  task automatic t_rmw();
    issue(2'b11, 1, 1, 1, 32'h0, 24'd6, 1, 1, 1, 1);  chk("R5 rmw len6", 0, 0, 8'd10, 1);
    issue(2'b11, 1, 1, 1, 32'h2, 24'd4, 1, 1, 1, 1);  chk("R5 rmw len4 half ok", 1, 0, 8'd0, 0);
    issue(2'b11, 1, 1, 1, 32'h1, 24'd4, 1, 1, 1, 1);  chk("R5 rmw len4 misaligned", 0, 0, 8'd10, 1);
    issue(2'b11, 1, 1, 1, 32'h2, 24'd8, 1, 1, 1, 1);  chk("R5 rmw len8 misaligned", 0, 0, 8'd10, 1);
    issue(2'b11, 1, 1, 1, 32'h3, 24'd7, 1, 1, 1, 1);  chk("R5 rmw len7 no align", 1, 0, 8'd0, 0);
    issue(2'b11, 1, 1, 1, 32'h0, 24'd12, 1, 1, 1, 1); chk("R5 rmw cargo big", 1, 0, 8'd6, 1);
  endtask

  task automatic t_dcrc();
    issue(2'b01, 1, 0, 1, 32'h0, 24'd4, 1, 1, 0, 1);  chk("R6 vw dcrc blocks", 0, 0, 8'd8, 1);
    issue(2'b01, 0, 1, 1, 32'h0, 24'd64, 1, 1, 0, 1); chk("R6 nvw dcrc late", 1, 0, 8'd8, 1);
    issue(2'b10, 0, 1, 1, 32'h0, 24'd4, 1, 1, 0, 1);  chk("R6 rd ignores dcrc", 1, 0, 8'd0, 0);
    issue(2'b11, 1, 1, 1, 32'h0, 24'd8, 1, 1, 0, 1);  chk("R6 rmw dcrc blocks", 0, 0, 8'd8, 1);
    issue(2'b01, 1, 0, 1, 32'h1, 24'd2, 1, 1, 0, 1);  chk("R10 rule over dcrc", 0, 0, 8'd10, 1);
  endtask

  task automatic t_no_reply();
    issue(2'b10, 0, 1, 0, 32'h0, 24'd4, 1, 1, 1, 1);  chk("R7 rd no reply", 0, 0, 8'd10, 1);
    issue(2'b11, 1, 1, 0, 32'h0, 24'd4, 1, 1, 1, 1);  chk("R7 rmw no reply", 0, 0, 8'd10, 1);
  endtask

  task automatic t_auth();
    issue(2'b10, 0, 1, 1, 32'h0, 24'd0, 0, 1, 1, 1);  chk("R8 auth fail len0", 0, 0, 8'd3, 1);
    issue(2'b01, 0, 0, 1, 32'h1, 24'd3, 0, 1, 1, 1);  chk("R10 key over rule", 0, 0, 8'd3, 1);
  endtask

  task automatic t_disabled();
    issue(2'b10, 0, 1, 1, 32'h0, 24'd4, 1, 1, 1, 0);  chk("R9 disabled rd", 0, 1, 8'd0, 0);
    issue(2'b01, 1, 0, 1, 32'h1, 24'd3, 0, 0, 0, 0);  chk("R9 disabled bad cmd", 0, 1, 8'd0, 0);
  endtask

  task automatic t_rank();
    issue(2'b00, 0, 0, 1, 32'h0, 24'd4, 0, 0, 1, 1);  chk("R10 hdr crc first", 0, 0, 8'd1, 1);
    issue(2'b00, 0, 0, 1, 32'h0, 24'd4, 0, 1, 1, 1);  chk("R10 type over key", 0, 0, 8'd2, 1);
  endtask

  task automatic t_hold();
    issue(2'b01, 1, 0, 1, 32'h0, 24'd4, 1, 1, 1, 1);  chk("R11 load", 1, 0, 8'd0, 0);
    @(negedge clk);
    cmd_type = 2'b00; hdr_crc_ok = 1'b0; tgt_en = 1'b0; key_hdr = ~KEY;
    repeat (3) @(negedge clk);
    chk("R11 hold without strobe", 1, 0, 8'd0, 0);
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R11 load after hold", 0, 1, 8'd0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_vwrite();
    t_incr_ignored();
    t_nvwrite();
    t_read();
    t_rmw();
    t_dcrc();
    t_no_reply();
    t_auth();
    t_disabled();
    t_rank();
    t_hold();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule